// File: doc/BRIEF.md
# Signed Int8 Booth Multiply-Accumulate Element

This block is one processing element of a small systolic matrix engine. It keeps a single signed 8-bit weight in a local register, and that weight stays in place until it is reloaded. On every enabled cycle the element multiplies the weight by an incoming signed 8-bit multiplicand and adds an incoming signed 8-bit summand. It registers the result, clamped to int8, for the next element in the array.

The product is formed by radix-4 Booth recoding of the multiplicand, which gives four partial products. These four and the sign-extended summand pass through a carry-save tree of 3:2 compressors and then one final carry-propagate add. The 17-bit sum is exact. It is saturated once, in the same cycle. The bits of the sum above the int8 range are captured in a debug register, together with the operands of the last compute. They are never forwarded.

Top module: `booth_mac_pe`

## Requirements
- R1: While rst_ni is low, the weight, multiplicand, summand, result and overflow registers are all zero.
- R2: At a clock edge with wgt_load_i high, the weight register takes wgt_i. Without wgt_load_i it holds its value across any number of computes.
- R3: At a clock edge with cmp_en_i high, res_o takes the clamped value of weight*mcand_i + sum_i. The weight used is the one held before that edge, so a load in the same cycle affects only later computes.
- R4: When the exact value of weight*mcand + summand lies in [-128, 127], res_o equals it exactly (two's complement).
- R5: An exact value above 127 gives res_o = 0x7F (127). An exact value below -128 gives res_o = 0x80 (-128).
- R6: dbg_ovf_o holds bits 16 down to 8 of the 17-bit two's-complement exact sum of the last compute.
- R7: dbg_mcand_o and dbg_sum_o hold the multiplicand and summand of the last compute. dbg_wgt_o shows the weight register.
- R8: At an edge with cmp_en_i low, res_o, dbg_ovf_o, dbg_mcand_o and dbg_sum_o keep their values.
- R9: The extreme operand -128 * -128 = 16384 is handled without wrap. Plus any summand, it saturates to 127 and dbg_ovf_o shows 0x040 for summand 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wgt_load_i | input | 1 | Load wgt_i into the weight register |
| wgt_i | input | 8 | Signed weight to load |
| cmp_en_i | input | 1 | Perform a multiply-add this cycle |
| mcand_i | input | 8 | Signed multiplicand |
| sum_i | input | 8 | Signed summand |
| res_o | output | 8 | Saturated signed result |
| dbg_wgt_o | output | 8 | Weight register |
| dbg_mcand_o | output | 8 | Multiplicand of the last compute |
| dbg_sum_o | output | 8 | Summand of the last compute |
| dbg_ovf_o | output | 9 | Bits of the exact sum above the int8 range |

## Verification
On every cycle, the assertions check the register discipline: the weight loads and holds, the operand and result registers capture and hold, and reset clears state. They also check that the result agrees with the overflow bits. A positive sum never yields a negative result, and any nonzero excess saturates to the matching rail. Arithmetic correctness of the Booth partial products and the compressor tree is shown only by the bench. Its reference model compares every output on every cycle, across pseudo-random operands, the extreme weight and multiplicand values, both clamp boundaries, and a load that coincides with a compute.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  typedef enum logic [2:0] {
    BD_ZERO,
    BD_POS1,
    BD_POS2,
    BD_NEG1,
    BD_NEG2
  } booth_dig_e;

  // triplet = {y[2i+1], y[2i], y[2i-1]}
  function automatic booth_dig_e booth_decode(logic [2:0] trip);
    unique case (trip)
      3'b001, 3'b010: return BD_POS1;
      3'b011:         return BD_POS2;
      3'b100:         return BD_NEG2;
      3'b101, 3'b110: return BD_NEG1;
      default:        return BD_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/booth_pp.sv
module booth_pp
  import booth_mac_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ACC_W = 17,
  parameter int IDX   = 0
) (
  input  logic [DW-1:0]    x_i,
  input  logic [2:0]       trip_i,
  output logic [ACC_W-1:0] pp_o
);

  localparam int SHIFT = 2 * IDX;

  logic [ACC_W-1:0] xe;
  logic [ACC_W-1:0] mag;
  booth_dig_e       dig;

  assign xe  = {{(ACC_W-DW){x_i[DW-1]}}, x_i};
  assign dig = booth_decode(trip_i);

  always_comb begin
    unique case (dig)
      BD_POS1: mag = xe;
      BD_POS2: mag = xe << 1;
      BD_NEG1: mag = ~xe + 1'b1;
      BD_NEG2: mag = ~(xe << 1) + 1'b1;
      default: mag = '0;
    endcase
  end

  assign pp_o = mag << SHIFT;

endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
  parameter int ACC_W = 17,
  parameter int NOPS  = 5
) (
  input  logic [NOPS-1:0][ACC_W-1:0] ops_i,
  output logic [ACC_W-1:0]           sum_o
);

  localparam int NLVL = NOPS - 1;

  logic [ACC_W-1:0] s_w [NLVL];
  logic [ACC_W-1:0] c_w [NLVL];

  assign s_w[0] = ops_i[0];
  assign c_w[0] = ops_i[1];

  // linear chain of 3:2 compressors, one new operand per level
  for (genvar j = 0; j < NOPS - 2; j++) begin : g_lvl
    assign s_w[j+1] = s_w[j] ^ c_w[j] ^ ops_i[j+2];
    assign c_w[j+1] = ((s_w[j] & c_w[j]) | (s_w[j] & ops_i[j+2]) |
                       (c_w[j] & ops_i[j+2])) << 1;
  end

  assign sum_o = s_w[NLVL-1] + c_w[NLVL-1];

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int DW    = 8,
  parameter int ACC_W = 17
) (
  input  logic [ACC_W-1:0]    acc_i,
  output logic [DW-1:0]       res_o,
  output logic [ACC_W-DW-1:0] ovf_o
);

  logic [ACC_W-DW:0] top;
  logic              in_rng;

  assign top    = acc_i[ACC_W-1:DW-1];
  assign in_rng = (&top) | ~(|top);
  assign ovf_o  = acc_i[ACC_W-1:DW];

  always_comb begin
    if (in_rng)             res_o = acc_i[DW-1:0];
    else if (acc_i[ACC_W-1]) res_o = {1'b1, {(DW-1){1'b0}}};
    else                     res_o = {1'b0, {(DW-1){1'b1}}};
  end

endmodule

// File: rtl/booth_mac_pe.sv
module booth_mac_pe #(
  parameter int DW    = 8,
  parameter int ACC_W = 2 * DW + 1,
  parameter int OVF_W = ACC_W - DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wgt_load_i,
  input  logic [DW-1:0]    wgt_i,
  input  logic             cmp_en_i,
  input  logic [DW-1:0]    mcand_i,
  input  logic [DW-1:0]    sum_i,
  output logic [DW-1:0]    res_o,
  output logic [DW-1:0]    dbg_wgt_o,
  output logic [DW-1:0]    dbg_mcand_o,
  output logic [DW-1:0]    dbg_sum_o,
  output logic [OVF_W-1:0] dbg_ovf_o
);

  localparam int NPP  = DW / 2;
  localparam int NOPS = NPP + 1;

  logic [DW-1:0]    wgt_q, mcand_q, sum_q, res_q;
  logic [OVF_W-1:0] ovf_q;

  logic [NOPS-1:0][ACC_W-1:0] ops;
  logic [ACC_W-1:0]           acc;
  logic [DW-1:0]              res_d;
  logic [OVF_W-1:0]           ovf_d;

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    logic [2:0] trip;
    if (i == 0) begin : g_lo
      assign trip = {mcand_i[1:0], 1'b0};
    end else begin : g_hi
      assign trip = mcand_i[2*i+1:2*i-1];
    end
    booth_pp #(.DW(DW), .ACC_W(ACC_W), .IDX(i)) u_pp (
      .x_i   (wgt_q),
      .trip_i(trip),
      .pp_o  (ops[i])
    );
  end

  assign ops[NPP] = {{(ACC_W-DW){sum_i[DW-1]}}, sum_i};

  csa_tree #(.ACC_W(ACC_W), .NOPS(NOPS)) u_tree (
    .ops_i(ops),
    .sum_o(acc)
  );

  sat_clamp #(.DW(DW), .ACC_W(ACC_W)) u_sat (
    .acc_i(acc),
    .res_o(res_d),
    .ovf_o(ovf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wgt_q <= '0;
    end else if (wgt_load_i) begin
      wgt_q <= wgt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      sum_q   <= '0;
      res_q   <= '0;
      ovf_q   <= '0;
    end else if (cmp_en_i) begin
      mcand_q <= mcand_i;
      sum_q   <= sum_i;
      res_q   <= res_d;
      ovf_q   <= ovf_d;
    end
  end

  assign res_o       = res_q;
  assign dbg_wgt_o   = wgt_q;
  assign dbg_mcand_o = mcand_q;
  assign dbg_sum_o   = sum_q;
  assign dbg_ovf_o   = ovf_q;

endmodule

// File: rtl/booth_mac_pe_chk.sv
module booth_mac_pe_chk #(
  parameter int DW    = 8,
  parameter int OVF_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wgt_load_i,
  input logic [DW-1:0]    wgt_i,
  input logic             cmp_en_i,
  input logic [DW-1:0]    mcand_i,
  input logic [DW-1:0]    sum_i,
  input logic [DW-1:0]    res_o,
  input logic [DW-1:0]    dbg_wgt_o,
  input logic [DW-1:0]    dbg_mcand_o,
  input logic [DW-1:0]    dbg_sum_o,
  input logic [OVF_W-1:0] dbg_ovf_o
);

  // R1
  rst_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (res_o == '0 && dbg_wgt_o == '0 && dbg_ovf_o == '0 &&
                 dbg_mcand_o == '0 && dbg_sum_o == '0));

  // R2
  wgt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wgt_load_i |=> dbg_wgt_o == $past(wgt_i));

  // R2
  wgt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wgt_load_i |=> $stable(dbg_wgt_o));

  // R7
  opnd_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i |=> (dbg_mcand_o == $past(mcand_i) && dbg_sum_o == $past(sum_i)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_en_i |=> ($stable(res_o) && $stable(dbg_ovf_o) &&
                   $stable(dbg_mcand_o) && $stable(dbg_sum_o)));

  // R5
  sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_ovf_o[OVF_W-1] == 1'b0) |-> (res_o[DW-1] == 1'b0));

  // R5
  pos_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_ovf_o[OVF_W-1] && dbg_ovf_o != '0) |-> res_o == {1'b0, {(DW-1){1'b1}}});

  // R5
  neg_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_ovf_o[OVF_W-1] && dbg_ovf_o != '1) |-> res_o == {1'b1, {(DW-1){1'b0}}});

endmodule

bind booth_mac_pe booth_mac_pe_chk #(.DW(DW), .OVF_W(OVF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wgt_load_i (wgt_load_i),
  .wgt_i      (wgt_i),
  .cmp_en_i   (cmp_en_i),
  .mcand_i    (mcand_i),
  .sum_i      (sum_i),
  .res_o      (res_o),
  .dbg_wgt_o  (dbg_wgt_o),
  .dbg_mcand_o(dbg_mcand_o),
  .dbg_sum_o  (dbg_sum_o),
  .dbg_ovf_o  (dbg_ovf_o)
);

// File: tb/booth_mac_pe_bench.sv
module booth_mac_pe_bench;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wgt_load_i = 1'b0;
  logic [7:0] wgt_i = '0;
  logic       cmp_en_i = 1'b0;
  logic [7:0] mcand_i = '0;
  logic [7:0] sum_i = '0;
  logic [7:0] res_o, dbg_wgt_o, dbg_mcand_o, dbg_sum_o;
  logic [8:0] dbg_ovf_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  // reference state
  int         m_w = 0;
  logic [7:0] m_res = '0, m_mc = '0, m_sm = '0;
  logic [8:0] m_ovf = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk_i = ~clk_i;

  booth_mac_pe u_booth_mac_pe (
    .clk_i(clk_i), .rst_ni(rst_ni), .wgt_load_i(wgt_load_i), .wgt_i(wgt_i),
    .cmp_en_i(cmp_en_i), .mcand_i(mcand_i), .sum_i(sum_i), .res_o(res_o),
    .dbg_wgt_o(dbg_wgt_o), .dbg_mcand_o(dbg_mcand_o), .dbg_sum_o(dbg_sum_o),
    .dbg_ovf_o(dbg_ovf_o)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " res"},   {8'h0, res_o},       {8'h0, m_res});
    check({tag, " ovf"},   {7'h0, dbg_ovf_o},   {7'h0, m_ovf});
    check({tag, " wgt"},   {8'h0, dbg_wgt_o},   16'(m_w[7:0]));
    check({tag, " mcand"}, {8'h0, dbg_mcand_o}, {8'h0, m_mc});
    check({tag, " sum"},   {8'h0, dbg_sum_o},   {8'h0, m_sm});
  endtask

  // drive at negedge, model the edge, sample 1 ns after it
  task automatic step(string tag, bit ld, logic [7:0] w, bit en,
                      logic [7:0] m, logic [7:0] s);
    int full;
    logic [16:0] f17;
    @(negedge clk_i);
    wgt_load_i = ld; wgt_i = w; cmp_en_i = en; mcand_i = m; sum_i = s;
    @(posedge clk_i);
    if (en) begin
      full = m_w * int'($signed(m)) + int'($signed(s));
      f17  = full[16:0];
      m_ovf = f17[16:8];
      if (full > 127)       m_res = 8'h7F;
      else if (full < -128) m_res = 8'h80;
      else                  m_res = full[7:0];
      m_mc = m; m_sm = s;
    end
    if (ld) m_w = int'($signed(w));
    #1;
    check_all(tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wgt_i = 8'h55; mcand_i = 8'hAA; sum_i = 8'h33; wgt_load_i = 1'b1; cmp_en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    check_all("R1 reset");
    @(negedge clk_i);
    wgt_load_i = 1'b0; cmp_en_i = 1'b0;
    rst_ni = 1'b1;

    step("R2 load", 1'b1, 8'd3, 1'b0, 8'd0, 8'd0);
    step("R4 exact", 1'b0, 8'h00, 1'b1, 8'd5, 8'hFE);        // 13
    step("R8 idle", 1'b0, 8'h00, 1'b0, 8'd40, 8'd40);
    step("R4 neg", 1'b0, 8'h00, 1'b1, 8'hF6, 8'd2);          // -28
    step("R3 ld+cmp", 1'b1, 8'hFB, 1'b1, 8'd7, 8'd1);        // old w=3 -> 22
    step("R3 new w", 1'b0, 8'h00, 1'b1, 8'd7, 8'd1);         // -34
    step("R4 bound hi", 1'b1, 8'd1, 1'b0, 8'd0, 8'd0);
    step("R4 127", 1'b0, 8'h00, 1'b1, 8'd127, 8'd0);
    step("R5 128", 1'b0, 8'h00, 1'b1, 8'd1, 8'd127);
    step("R4 -128", 1'b0, 8'h00, 1'b1, 8'h80, 8'd0);
    step("R5 -129", 1'b0, 8'h00, 1'b1, 8'h80, 8'hFF);
    step("R9 ld", 1'b1, 8'h80, 1'b0, 8'd0, 8'd0);
    step("R9 max", 1'b0, 8'h00, 1'b1, 8'h80, 8'd127);        // 16511
    check("R9 ovf", {7'h0, dbg_ovf_o}, 16'h0040);
    step("R9 min", 1'b0, 8'h00, 1'b1, 8'd127, 8'h80);        // -16384
    step("R6 zero", 1'b0, 8'h00, 1'b1, 8'd0, 8'hC0);
    step("R8 hold", 1'b0, 8'h00, 1'b0, 8'h80, 8'h80);

    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R3 R6 R7 rand", lfsr[3:0] == 4'h0, lfsr[15:8], lfsr[4] | lfsr[5],
           lfsr[23:16], lfsr[31:24]);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule